// File: doc/BRIEF.md
# Gradient Block Aggregation Engine

This engine sums integer gradient blocks that several sources contribute to a shared training job. It then emits one result packet per block once every participating source has delivered its part. A control port installs a job record before traffic starts and removes it when the job ends. The record holds the set of participating sources, the number of blocks in the job, and a destination tag that is copied into each result header. Collective packets arrive already parsed, one 32-bit payload word per beat. The job, block, source and element count fields are held constant on every beat of a packet.

No per-block state exists until the first contribution for a block arrives. That contribution claims a buffer slot from a small pool and writes its payload as the starting sum. Later contributions from other sources add into the slot word by word. A pending-source mask shows who is still missing. When the mask empties, the slot is streamed out as a result packet and released. A background scan visits one slot per cycle and aborts any block that has gone quiet for too long. It reports the job, the block and the sources that never arrived. Packets that cannot be used are consumed and counted, never stalled.

Top module: `grad_agg`

## Requirements
- R1: After reset `out_valid` and `to_valid` are 0, `in_ready` is 1 and `drop_cnt` is 0.
- R2: A packet whose job has no installed record is consumed and adds 1 to `drop_cnt`. This applies to a job never installed and to one removed with `cfg_install`=0. A job installed with `cfg_install`=1 accepts traffic from the next cycle.
- R3: A packet whose source bit (`1 << in_src`) is clear in the job's participant mask is consumed, counted in `drop_cnt` and has no effect on any sum. The same holds for a packet whose block number is not below the job's block count.
- R4: The first accepted contribution to a block sets each buffer word to its payload word. Each later one adds its word i into buffer word i, modulo 2^32.
- R5: When the last missing source of the mask has delivered its last beat, a result packet is emitted starting the next cycle. Its header carries the block's job, block, element count (taken from the first contribution) and the job's destination tag. It carries one summed word per accepted output beat in element order, with `out_last` high on the final word.
- R6: While `out_valid` is high and `out_ready` low, every output holds its value. `in_ready` is low for as long as a result is being emitted.
- R7: A contribution from a source that has already delivered to the same open block is consumed, counted in `drop_cnt` and not added.
- R8: At most NUM_BUF blocks are open at once. A first contribution to a further block while all slots are open is consumed and counted.
- R9: A block whose last accepted beat lies TIMEOUT or more cycles back is closed and its slot freed. This happens within TIMEOUT+NUM_BUF+3 cycles of that beat, with a one-cycle `to_valid` carrying its job, block and mask of missing sources. A later contribution to that block opens a fresh sum.
- R10: A completed block's slot is freed, so the same job and block (or a new one) can be aggregated again, even after a pool-full refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Job record write strobe |
| cfg_install | input | 1 | 1 installs the record, 0 removes it |
| cfg_job | input | JOB_W | Job index being written |
| cfg_mask | input | NUM_SRC | Participating sources |
| cfg_nblk | input | BLK_W+1 | Number of blocks in the job |
| cfg_dest | input | DEST_W | Result destination tag |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_job | input | JOB_W | Job of the packet |
| in_blk | input | BLK_W | Block of the packet |
| in_src | input | SRC_W | Source of the packet |
| in_cnt | input | CNT_W | Element count, 1..MAX_ELEM |
| in_data | input | 32 | Payload word |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result beat accepted |
| out_job | output | JOB_W | Result job |
| out_blk | output | BLK_W | Result block |
| out_cnt | output | CNT_W | Result element count |
| out_dest | output | DEST_W | Result destination tag |
| out_data | output | 32 | Summed word |
| out_last | output | 1 | Final word of the result |
| to_valid | output | 1 | Timeout event pulse |
| to_job | output | JOB_W | Job of the aborted block |
| to_blk | output | BLK_W | Aborted block |
| to_missing | output | NUM_SRC | Sources that never delivered |
| drop_cnt | output | DROP_W | Count of discarded packets |

## Verification
A corrupted pending mask shows up either as a result packet that comes one source too early, with a short sum, or as no result at all. The second case is then reported by a timeout event about TIMEOUT cycles later, with a wrong missing mask. A wrong slot match or allocation shows up in the first result word, in the cycle after the completing beat, as a sum that mixes two blocks. It also shows as an unexpected pool-full drop on the next new block. Counter faults are visible in `drop_cnt` on the cycle after the offending first beat.

// File: rtl/grad_agg_pkg.sv
package grad_agg_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // why a first beat is refused (internal decision code)
  typedef enum logic [2:0] {
    DR_NONE,
    DR_NOJOB,
    DR_NOTMEMBER,
    DR_BADBLK,
    DR_DUP,
    DR_FULL
  } drop_e;
endpackage

// File: rtl/grad_agg_jobtab.sv
module grad_agg_jobtab #(
  parameter int NUM_JOBS = 4,
  parameter int NUM_SRC  = 4,
  parameter int BLK_W    = 3,
  parameter int DEST_W   = 8,
  localparam int JOB_W   = $clog2(NUM_JOBS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_install,
  input  logic [JOB_W-1:0]  cfg_job,
  input  logic [NUM_SRC-1:0] cfg_mask,
  input  logic [BLK_W:0]    cfg_nblk,
  input  logic [DEST_W-1:0] cfg_dest,
  input  logic [JOB_W-1:0]  lk_job,
  output logic              lk_vld,
  output logic [NUM_SRC-1:0] lk_mask,
  output logic [BLK_W:0]    lk_nblk,
  output logic [DEST_W-1:0] lk_dest
);
  logic [NUM_JOBS-1:0] vld;
  logic [NUM_SRC-1:0]  mask_q [NUM_JOBS];
  logic [BLK_W:0]      nblk_q [NUM_JOBS];
  logic [DEST_W-1:0]   dest_q [NUM_JOBS];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (cfg_we) begin
      vld[cfg_job] <= cfg_install;
    end
    if (cfg_we && cfg_install) begin
      mask_q[cfg_job] <= cfg_mask;
      nblk_q[cfg_job] <= cfg_nblk;
      dest_q[cfg_job] <= cfg_dest;
    end
  end

  assign lk_vld  = vld[lk_job];
  assign lk_mask = mask_q[lk_job];
  assign lk_nblk = nblk_q[lk_job];
  assign lk_dest = dest_q[lk_job];
endmodule

// File: rtl/grad_agg_bufmem.sv
module grad_agg_bufmem
  import grad_agg_pkg::*;
#(
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] ra_addr,
  output word_t         ra_data,
  input  logic [AW-1:0] rb_addr,
  output word_t         rb_data
);
  // small dual-read distributed RAM: read-modify-write port and drain port
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/grad_agg_emit.sv
module grad_agg_emit #(
  parameter int SLOT_W = 1,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3,
  parameter int JOB_W  = 2,
  parameter int BLK_W  = 3,
  parameter int DEST_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SLOT_W-1:0]       st_slot,
  input  logic [JOB_W-1:0]        st_job,
  input  logic [BLK_W-1:0]        st_blk,
  input  logic [CNT_W-1:0]        st_cnt,
  input  logic [DEST_W-1:0]       st_dest,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [SLOT_W+IDX_W-1:0] rd_addr,
  output logic [JOB_W-1:0]        out_job,
  output logic [BLK_W-1:0]        out_blk,
  output logic [CNT_W-1:0]        out_cnt,
  output logic [DEST_W-1:0]       out_dest,
  output logic                    out_last
);
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      idx       <= '0;
    end else if (start) begin
      out_valid <= 1'b1;
      idx       <= '0;
      slot      <= st_slot;
      out_job   <= st_job;
      out_blk   <= st_blk;
      out_cnt   <= st_cnt;
      out_dest  <= st_dest;
    end else if (out_valid && out_ready) begin
      if (out_last) out_valid <= 1'b0;
      else          idx <= idx + CNT_W'(1);
    end
  end

  assign out_last = out_valid && (idx == out_cnt - CNT_W'(1));
  assign rd_addr  = {slot, idx[IDX_W-1:0]};
endmodule

// File: rtl/grad_agg.sv
module grad_agg
  import grad_agg_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int NUM_JOBS = 4,
  parameter int BLK_W    = 3,
  parameter int MAX_ELEM = 4,
  parameter int NUM_BUF  = 2,
  parameter int DEST_W   = 8,
  parameter int TIMEOUT  = 64,
  parameter int DROP_W   = 16,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int JOB_W   = $clog2(NUM_JOBS),
  localparam int IDX_W   = $clog2(MAX_ELEM),
  localparam int CNT_W   = $clog2(MAX_ELEM + 1),
  localparam int SLOT_W  = $clog2(NUM_BUF),
  localparam int AGE_W   = $clog2(TIMEOUT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_install,
  input  logic [JOB_W-1:0]   cfg_job,
  input  logic [NUM_SRC-1:0] cfg_mask,
  input  logic [BLK_W:0]     cfg_nblk,
  input  logic [DEST_W-1:0]  cfg_dest,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [JOB_W-1:0]   in_job,
  input  logic [BLK_W-1:0]   in_blk,
  input  logic [SRC_W-1:0]   in_src,
  input  logic [CNT_W-1:0]   in_cnt,
  input  logic [31:0]        in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [JOB_W-1:0]   out_job,
  output logic [BLK_W-1:0]   out_blk,
  output logic [CNT_W-1:0]   out_cnt,
  output logic [DEST_W-1:0]  out_dest,
  output logic [31:0]        out_data,
  output logic               out_last,
  output logic               to_valid,
  output logic [JOB_W-1:0]   to_job,
  output logic [BLK_W-1:0]   to_blk,
  output logic [NUM_SRC-1:0] to_missing,
  output logic [DROP_W-1:0]  drop_cnt
);
  // job table lookup
  logic               lk_vld;
  logic [NUM_SRC-1:0] lk_mask;
  logic [BLK_W:0]     lk_nblk;
  logic [DEST_W-1:0]  lk_dest;

  grad_agg_jobtab #(.NUM_JOBS(NUM_JOBS), .NUM_SRC(NUM_SRC), .BLK_W(BLK_W), .DEST_W(DEST_W)) u_jobs (
    .clk, .rst, .cfg_we, .cfg_install, .cfg_job, .cfg_mask, .cfg_nblk, .cfg_dest,
    .lk_job(in_job), .lk_vld, .lk_mask, .lk_nblk, .lk_dest
  );

  // open-block slot state
  logic [NUM_BUF-1:0] slot_vld;
  logic [JOB_W-1:0]   slot_job  [NUM_BUF];
  logic [BLK_W-1:0]   slot_blk  [NUM_BUF];
  logic [CNT_W-1:0]   slot_cnt  [NUM_BUF];
  logic [DEST_W-1:0]  slot_dest [NUM_BUF];
  logic [NUM_SRC-1:0] slot_pend [NUM_BUF];
  logic [AGE_W-1:0]   slot_age  [NUM_BUF];

  // packet walk state
  logic [CNT_W-1:0]  pkt_idx;
  logic              pkt_acc, pkt_fresh;
  logic [SLOT_W-1:0] pkt_slot;
  logic [SLOT_W-1:0] scan_ptr;

  logic              emit_busy;
  logic              beat, first, last, acc, fresh, done;
  logic              hit, any_free;
  logic [SLOT_W-1:0] hit_slot, free_slot, cur_slot;
  logic [NUM_SRC-1:0] src_bit, base_pend, new_pend;
  drop_e             reason;
  word_t             acc_rd, wr_data;
  logic [SLOT_W+IDX_W-1:0] wr_addr, rd_addr;

  assign in_ready = !emit_busy;
  assign beat     = in_valid && in_ready;
  assign first    = (pkt_idx == '0);
  assign last     = (pkt_idx == in_cnt - CNT_W'(1));
  assign src_bit  = NUM_SRC'(1) << in_src;

  // associative match of open blocks and lowest free slot
  always_comb begin
    hit = 1'b0; hit_slot = '0; any_free = 1'b0; free_slot = '0;
    for (int s = 0; s < NUM_BUF; s++) begin
      if (!hit && slot_vld[s] && slot_job[s] == in_job && slot_blk[s] == in_blk) begin
        hit = 1'b1; hit_slot = SLOT_W'(s);
      end
      if (!any_free && !slot_vld[s]) begin
        any_free = 1'b1; free_slot = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    if (!lk_vld)                                  reason = DR_NOJOB;
    else if ((lk_mask & src_bit) == '0)           reason = DR_NOTMEMBER;
    else if ({1'b0, in_blk} >= lk_nblk)           reason = DR_BADBLK;
    else if (hit && (slot_pend[hit_slot] & src_bit) == '0) reason = DR_DUP;
    else if (!hit && !any_free)                   reason = DR_FULL;
    else                                          reason = DR_NONE;
  end

  always_comb begin
    if (first) begin
      acc       = (reason == DR_NONE);
      fresh     = !hit;
      cur_slot  = hit ? hit_slot : free_slot;
      base_pend = hit ? slot_pend[hit_slot] : lk_mask;
    end else begin
      acc       = pkt_acc;
      fresh     = pkt_fresh;
      cur_slot  = pkt_slot;
      base_pend = slot_pend[pkt_slot];
    end
  end

  assign new_pend = base_pend & ~src_bit;
  assign done     = beat && acc && last && (new_pend == '0);
  assign wr_addr  = {cur_slot, pkt_idx[IDX_W-1:0]};
  assign wr_data  = fresh ? in_data : acc_rd + in_data;

  grad_agg_bufmem #(.AW(SLOT_W + IDX_W)) u_mem (
    .clk, .we(beat && acc), .waddr(wr_addr), .wdata(wr_data),
    .ra_addr(wr_addr), .ra_data(acc_rd), .rb_addr(rd_addr), .rb_data(out_data)
  );

  grad_agg_emit #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .JOB_W(JOB_W),
                  .BLK_W(BLK_W), .DEST_W(DEST_W)) u_emit (
    .clk, .rst, .start(done), .st_slot(cur_slot), .st_job(in_job), .st_blk(in_blk),
    .st_cnt((first && fresh) ? in_cnt : slot_cnt[cur_slot]),
    .st_dest((first && fresh) ? lk_dest : slot_dest[cur_slot]),
    .out_ready, .out_valid(emit_busy), .rd_addr, .out_job, .out_blk, .out_cnt,
    .out_dest, .out_last
  );
  assign out_valid = emit_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      pkt_idx  <= '0;
      pkt_acc  <= 1'b0;
      drop_cnt <= '0;
      to_valid <= 1'b0;
      scan_ptr <= '0;
    end else begin
      to_valid <= 1'b0;
      for (int s = 0; s < NUM_BUF; s++)
        if (slot_vld[s] && slot_age[s] < AGE_W'(TIMEOUT)) slot_age[s] <= slot_age[s] + AGE_W'(1);
      scan_ptr <= (scan_ptr == SLOT_W'(NUM_BUF - 1)) ? '0 : scan_ptr + SLOT_W'(1);
      if (beat) begin
        pkt_idx <= last ? '0 : pkt_idx + CNT_W'(1);
        if (first) begin
          pkt_acc   <= acc;
          pkt_fresh <= fresh;
          pkt_slot  <= cur_slot;
          if (!acc) drop_cnt <= drop_cnt + DROP_W'(1);
        end
        if (acc) begin
          slot_vld[cur_slot]  <= !done;
          slot_pend[cur_slot] <= last ? new_pend : base_pend;
          slot_age[cur_slot]  <= '0;
          if (first && fresh) begin
            slot_job[cur_slot]  <= in_job;
            slot_blk[cur_slot]  <= in_blk;
            slot_cnt[cur_slot]  <= in_cnt;
            slot_dest[cur_slot] <= lk_dest;
          end
        end
      end else if (pkt_idx == '0 && slot_vld[scan_ptr] && slot_age[scan_ptr] >= AGE_W'(TIMEOUT)) begin
        slot_vld[scan_ptr] <= 1'b0;
        to_valid   <= 1'b1;
        to_job     <= slot_job[scan_ptr];
        to_blk     <= slot_blk[scan_ptr];
        to_missing <= slot_pend[scan_ptr];
      end
    end
  end
endmodule

// File: rtl/grad_agg_chk.sv
module grad_agg_chk #(
  parameter int NUM_SRC = 4,
  parameter int JOB_W   = 2,
  parameter int DROP_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [JOB_W-1:0]   out_job,
  input logic [31:0]        out_data,
  input logic               out_last,
  input logic               to_valid,
  input logic [NUM_SRC-1:0] to_missing,
  input logic [DROP_W-1:0]  drop_cnt
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_job) && $stable(out_last));

  // R6
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R9
  to_missing_chk: assert property (@(posedge clk) disable iff (rst)
    to_valid |-> (to_missing != '0));

  // R2
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

  // R3
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt)) || $past(in_valid && in_ready));
endmodule

bind grad_agg grad_agg_chk #(.NUM_SRC(NUM_SRC), .JOB_W(JOB_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_job(out_job), .out_data(out_data), .out_last(out_last),
  .to_valid(to_valid), .to_missing(to_missing), .drop_cnt(drop_cnt)
);

// File: tb/sim_grad_agg.sv
module sim_grad_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4, NJOB = 4, BW = 3, ME = 4, NB = 2, DW = 8, TO = 64, DRW = 16;
  localparam int SW = 2, JW = 2, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_install = 0;
  logic [JW-1:0] cfg_job = '0;
  logic [NSRC-1:0] cfg_mask = '0;
  logic [BW:0] cfg_nblk = '0;
  logic [DW-1:0] cfg_dest = '0;
  logic in_valid = 0, in_ready;
  logic [JW-1:0] in_job = '0;
  logic [BW-1:0] in_blk = '0;
  logic [SW-1:0] in_src = '0;
  logic [CW-1:0] in_cnt = '0;
  logic [31:0] in_data = '0;
  logic out_valid, out_ready = 1'b1, out_last, to_valid;
  logic [JW-1:0] out_job, to_job;
  logic [BW-1:0] out_blk, to_blk;
  logic [CW-1:0] out_cnt;
  logic [DW-1:0] out_dest;
  logic [31:0] out_data;
  logic [NSRC-1:0] to_missing;
  logic [DRW-1:0] drop_cnt;

  int nchk = 0, nfail = 0, exp_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grad_agg #(.NUM_SRC(NSRC), .NUM_JOBS(NJOB), .BLK_W(BW), .MAX_ELEM(ME), .NUM_BUF(NB),
             .DEST_W(DW), .TIMEOUT(TO), .DROP_W(DRW)) u0 (.*);

  function automatic logic [31:0] val(int s, int b, int i);
    return 32'hC000_0000 + 32'(s << 20) + 32'(b << 8) + 32'(i * 3 + 1);
  endfunction

  function automatic logic [31:0] esum(logic [NSRC-1:0] m, int b, int i);
    logic [31:0] t = '0;
    for (int s = 0; s < NSRC; s++) if (m[s]) t = t + val(s, b, i);
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int job, logic inst, logic [NSRC-1:0] m, int nb);
    @(negedge clk);
    cfg_we = 1; cfg_install = inst; cfg_job = JW'(job); cfg_mask = m;
    cfg_nblk = (BW+1)'(nb); cfg_dest = DW'(job * 16 + 3);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(int job, int blk, int src, int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      in_valid = 1; in_job = JW'(job); in_blk = BW'(blk); in_src = SW'(src);
      in_cnt = CW'(cnt); in_data = val(src, blk, i);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic recv(string req, int job, int blk, int cnt, logic [NSRC-1:0] m);
    for (int i = 0; i < cnt; i++) begin
      for (int w = 0; w < 20 && !out_valid; w++) @(negedge clk);
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      if (i == 0) begin
        chk({req, " job"}, 32'(out_job), 32'(job));
        chk({req, " blk"}, 32'(out_blk), 32'(blk));
        chk({req, " cnt"}, 32'(out_cnt), 32'(cnt));
        chk({req, " dest"}, 32'(out_dest), 32'(job * 16 + 3));
      end
      chk({req, " R4 sum"}, out_data, esum(m, blk, i));
      chk({req, " last"}, 32'(out_last), 32'(i == cnt - 1));
      @(negedge clk);
    end
    chk({req, " done"}, 32'(out_valid), 32'd0);
  endtask

  task automatic drop_chk(string req);
    exp_drop++;
    chk({req, " drop_cnt"}, 32'(drop_cnt), 32'(exp_drop));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 to_valid", 32'(to_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 drop_cnt", 32'(drop_cnt), 0);

    // R2: uninstalled job
    send(0, 0, 0, 2); drop_chk("R2 nojob");
    cfg(0, 1, 4'b1111, 8);
    cfg(1, 1, 4'b1111, 8);
    cfg(2, 1, 4'b0011, 4);
    cfg(3, 1, 4'b0011, 8);

    // R4/R5 sweep: every count, rotated source orders
    for (int c = 1; c <= ME; c++)
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < NSRC; k++) send(0, b, (c + b + k) % NSRC, c);
        recv("R5 sweep", 0, b, c, 4'b1111);
      end

    // R3: non-member source, block out of range
    send(2, 1, 2, 3); drop_chk("R3 member");
    send(2, 4, 0, 3); drop_chk("R3 blk");
    send(2, 1, 0, 3); send(2, 1, 1, 3);
    recv("R3 excl", 2, 1, 3, 4'b0011);

    // R7 duplicate
    send(2, 3, 0, 4); send(2, 3, 0, 4); drop_chk("R7 dup");
    send(2, 3, 1, 4);
    recv("R7 once", 2, 3, 4, 4'b0011);

    // R8 pool exhaustion then R10 reuse
    send(1, 0, 0, 2); send(1, 1, 0, 2);
    send(1, 2, 0, 2); drop_chk("R8 full");
    for (int s = 1; s < NSRC; s++) send(1, 0, s, 2);
    recv("R8 b0", 1, 0, 2, 4'b1111);
    for (int s = 1; s < NSRC; s++) send(1, 1, s, 2);
    recv("R8 b1", 1, 1, 2, 4'b1111);
    for (int s = 0; s < NSRC; s++) send(1, 2, s, 2);
    recv("R10 reuse", 1, 2, 2, 4'b1111);
    for (int s = NSRC - 1; s >= 0; s--) send(1, 0, s, 1);
    recv("R10 again", 1, 0, 1, 4'b1111);

    // R6 backpressure
    out_ready = 0;
    for (int s = 0; s < NSRC; s++) send(0, 6, s, 4);
    begin
      logic [31:0] held;
      held = out_data;
      chk("R6 valid", 32'(out_valid), 1);
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        chk("R6 hold", out_data, held);
        chk("R6 in_ready", 32'(in_ready), 0);
      end
    end
    out_ready = 1;
    recv("R6 drain", 0, 6, 4, 4'b1111);

    // R9 timeout and fresh restart
    send(3, 5, 0, 2);
    begin
      int n;
      n = -1;
      for (int w = 0; w < TO + NB + 10; w++) begin
        if (to_valid && n < 0) begin
          n = w;
          chk("R9 job", 32'(to_job), 3);
          chk("R9 blk", 32'(to_blk), 5);
          chk("R9 missing", 32'(to_missing), 32'b0010);
        end
        @(negedge clk);
      end
      chk("R9 seen", 32'(n >= TO - 2 && n <= TO + NB + 3), 1);
    end
    send(3, 5, 1, 2); send(3, 5, 0, 2);
    recv("R9 fresh", 3, 5, 2, 4'b0011);

    // R2 removed job
    cfg(0, 0, 4'b1111, 8);
    send(0, 1, 0, 2); drop_chk("R2 removed");
    chk("R2 quiet", 32'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule